// File: doc/BRIEF.md
# Stack-Machine Byte Processor

This block is a compact processor for an 8-bit instruction set in which every operand lives on a hardware stack. Each instruction is one byte. The upper three bits select the operation, and the lower five bits carry either a memory address, a small signed constant, or nothing. Code and data share one 32-byte memory, so a program can store a value over one of its own instructions and later fetch the changed byte.

A host uses the block in three phases. While the core is idle, the host loads memory bytes and seeds the operand stack through the debug port. The host then pulses `run`, and the core executes from address 0 until it reaches a halt instruction or detects a fault. After that, the host reads back memory, the stack depth, every stack entry, the program counter and the fault flags. A halted core stays halted until reset.

Each instruction completes in two cycles: a fetch and a decode/execute cycle. A push from memory needs a third cycle to read its data byte.

Top module: `stk8_core`

## Requirements
- R1: After reset the core is idle: `halted` is 0, `pc` is 0, the stack depth is 0 and all three fault flags are 0. Memory contents are not changed by reset.
- R2: The opcode is taken from bits 7..5 and the operand from bits 4..0. Opcode encodings: 000 add, 001 nand, 010 push-from-address, 011 pop-to-address, 100 push-immediate, 101 branch-if-equal, 110 halt, 111 undefined. For example, 0x4A pushes the byte at address 10.
- R3: add (000) removes the top two entries and pushes their sum modulo 256. nand (001) removes the top two entries and pushes their bitwise NAND.
- R4: push (010) pushes the byte stored at the operand address. pop (011) removes the top entry and writes it to the operand address.
- R5: push-immediate (100) sign-extends the 5-bit operand (-16..15) to 8 bits and pushes it.
- R6: branch-if-equal (101) compares the top two entries. If they are equal, it removes both and loads `pc` with the operand. Otherwise the stack is unchanged and `pc` advances by one.
- R7: halt (110) advances `pc` by one and then raises `halted`. While halted, `run` has no effect.
- R8: The stack holds 16 entries. A push onto a full stack sets the sticky `err_overflow` flag and halts the core. The stack, `pc` and memory are left unchanged, and `pc` still points at the faulting instruction.
- R9: An instruction that needs more entries than the stack holds (one for pop, two for add, nand and branch) sets the sticky `err_underflow` flag and halts the core. The stack and `pc` are left unchanged.
- R10: Opcode 111 sets `err_illegal` and halts the core. So do add, nand and halt when their low five bits are not zero. In both cases `pc` stays at the faulting instruction.
- R11: Instruction fetch and data access use the same memory. A pop onto a code address changes the instruction fetched later from that address.
- R12: `pc` is 5 bits wide and wraps from 31 to 0.
- R13: Debug memory writes and debug stack pushes take effect only while the core is idle. A debug push onto a full stack is ignored. Memory reads return the byte at `dbg_addr` one cycle after the address is presented, while the core is idle or halted. Stack entries are read by index, where index 0 is the bottom of the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start execution from idle |
| dbg_mem_we | input | 1 | Debug memory write strobe (idle only) |
| dbg_addr | input | 5 | Debug memory address for read and write |
| dbg_wdata | input | 8 | Debug write data for memory or stack |
| dbg_stk_push | input | 1 | Debug stack push strobe (idle only) |
| dbg_stk_idx | input | 4 | Stack entry index for readback, 0 = bottom |
| halted | output | 1 | Core has stopped |
| err_overflow | output | 1 | Sticky stack overflow fault |
| err_underflow | output | 1 | Sticky stack underflow fault |
| err_illegal | output | 1 | Sticky illegal instruction fault |
| pc | output | 5 | Program counter |
| dbg_mem_rdata | output | 8 | Registered memory read data |
| dbg_stk_depth | output | 5 | Current number of stack entries |
| dbg_stk_data | output | 8 | Stack entry selected by `dbg_stk_idx` |

## Verification
The assertions assume that reset is held for at least one clock before the first `run`. They also assume that the host changes memory and the stack only through the debug strobes while the core is idle, and that it never asserts `dbg_mem_we` and `dbg_stk_push` in the same cycle. The bench resets the core before every scenario. It drives the strobes one at a time, for a single cycle each, on the falling edge, and pulses `run` only after all preloads are done. The one exception is a deliberate test of the strobes while the core is halted, where the core must ignore them.

// File: rtl/stk8_pkg.sv
package stk8_pkg;
  localparam int DATA_W    = 8;
  localparam int OP_W      = 3;
  localparam int ARG_W     = DATA_W - OP_W;
  localparam int MEM_WORDS = 1 << ARG_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'b000,
    OP_NAND  = 3'b001,
    OP_LOAD  = 3'b010,
    OP_STORE = 3'b011,
    OP_IMM   = 3'b100,
    OP_BEQ   = 3'b101,
    OP_STOP  = 3'b110,
    OP_BAD   = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    SOP_NONE,
    SOP_PUSH,
    SOP_POP1,
    SOP_POP2,
    SOP_REDUCE
  } stk_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DECODE,
    S_LOAD,
    S_HALT
  } core_state_e;
endpackage

// File: rtl/stk8_mem.sv
module stk8_mem #(
  parameter int AW = 5,
  parameter int DW = 8,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [WORDS];

  // One synchronous write port and one synchronous read port, no reset,
  // so the array maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/stk8_stack.sv
module stk8_stack
  import stk8_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] depth,
  output logic [DW-1:0] top,
  output logic [DW-1:0] second,
  output logic          full,
  output logic          has1,
  output logic          has2,
  input  logic [IW-1:0] dbg_idx,
  output logic [DW-1:0] dbg_data
);
  logic [DW-1:0] ent [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] i_top, i_sec, i_new;

  assign i_new  = IW'(cnt_q);
  assign i_top  = IW'(cnt_q - CW'(1));
  assign i_sec  = IW'(cnt_q - CW'(2));
  assign full   = (cnt_q == CW'(DEPTH));
  assign has1   = (cnt_q != '0);
  assign has2   = (cnt_q >= CW'(2));
  assign top    = has1 ? ent[i_top] : '0;
  assign second = has2 ? ent[i_sec] : '0;
  assign depth  = cnt_q;
  assign dbg_data = ent[dbg_idx];

  // Entry storage: written only by pushes and by the reducing ALU ops.
  always_ff @(posedge clk) begin
    if (op == SOP_PUSH && !full) ent[i_new] <= wdata;
    else if (op == SOP_REDUCE && has2) ent[i_sec] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else begin
      unique case (op)
        SOP_PUSH:   if (!full) cnt_q <= cnt_q + CW'(1);
        SOP_POP1:   if (has1)  cnt_q <= cnt_q - CW'(1);
        SOP_POP2:   if (has2)  cnt_q <= cnt_q - CW'(2);
        SOP_REDUCE: if (has2)  cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end

  // R8: an accepted push grows the stack by exactly one
  a_r8_push_grows: assert property (@(posedge clk) disable iff (rst)
    (op == SOP_PUSH && !full) |=> (cnt_q == CW'($past(cnt_q) + CW'(1))));
  // R9: the controller never asks for two operands that are not there
  a_r9_two_operands: assert property (@(posedge clk) disable iff (rst)
    (op == SOP_POP2 || op == SOP_REDUCE) |-> has2);
  // R9: the controller never pops an empty stack
  a_r9_one_operand: assert property (@(posedge clk) disable iff (rst)
    (op == SOP_POP1) |-> has1);
endmodule

// File: rtl/stk8_alu.sv
module stk8_alu #(
  parameter int DW = 8
) (
  input  logic          sel_nand,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    if (sel_nand) y = ~(a & b);
    else          y = a + b;
  end
endmodule

// File: rtl/stk8_core.sv
module stk8_core
  import stk8_pkg::*;
#(
  parameter int STACK_DEPTH = 16,
  localparam int CW = $clog2(STACK_DEPTH + 1),
  localparam int IW = $clog2(STACK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              dbg_mem_we,
  input  logic [ARG_W-1:0]  dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  input  logic              dbg_stk_push,
  input  logic [IW-1:0]     dbg_stk_idx,
  output logic              halted,
  output logic              err_overflow,
  output logic              err_underflow,
  output logic              err_illegal,
  output logic [ARG_W-1:0]  pc,
  output logic [DATA_W-1:0] dbg_mem_rdata,
  output logic [CW-1:0]     dbg_stk_depth,
  output logic [DATA_W-1:0] dbg_stk_data
);
  core_state_e       state_q, state_d;
  logic [ARG_W-1:0]  pc_q, pc_d;
  logic              ovf_q, ovf_d, unf_q, unf_d, ill_q, ill_d;

  logic              mem_we;
  logic [ARG_W-1:0]  mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  stk_op_e           stk_op;
  logic [DATA_W-1:0] stk_wdata, stk_top, stk_sec, alu_y;
  logic              stk_full, stk_has1, stk_has2;

  opcode_e           ins_op;
  logic [ARG_W-1:0]  ins_arg;
  logic [DATA_W-1:0] imm_ext;

  assign ins_op  = opcode_e'(mem_rdata[DATA_W-1:ARG_W]);
  assign ins_arg = mem_rdata[ARG_W-1:0];
  assign imm_ext = {{(DATA_W-ARG_W){ins_arg[ARG_W-1]}}, ins_arg};

  stk8_mem #(.AW(ARG_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  stk8_stack #(.DEPTH(STACK_DEPTH), .DW(DATA_W)) u_stack (
    .clk(clk), .rst(rst), .op(stk_op), .wdata(stk_wdata),
    .depth(dbg_stk_depth), .top(stk_top), .second(stk_sec),
    .full(stk_full), .has1(stk_has1), .has2(stk_has2),
    .dbg_idx(dbg_stk_idx), .dbg_data(dbg_stk_data)
  );

  stk8_alu #(.DW(DATA_W)) u_alu (
    .sel_nand(ins_op == OP_NAND), .a(stk_sec), .b(stk_top), .y(alu_y)
  );

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ovf_d     = ovf_q;
    unf_d     = unf_q;
    ill_d     = ill_q;
    stk_op    = SOP_NONE;
    stk_wdata = alu_y;
    mem_we    = 1'b0;
    mem_waddr = dbg_addr;
    mem_wdata = dbg_wdata;
    mem_raddr = dbg_addr;
    unique case (state_q)
      S_IDLE: begin
        if (dbg_mem_we) mem_we = 1'b1;
        else if (dbg_stk_push && !stk_full) begin
          stk_op    = SOP_PUSH;
          stk_wdata = dbg_wdata;
        end
        if (run) state_d = S_FETCH;
      end
      S_FETCH: begin
        mem_raddr = pc_q;
        state_d   = S_DECODE;
      end
      S_DECODE: begin
        mem_raddr = ins_arg;
        state_d   = S_FETCH;
        unique case (ins_op)
          OP_ADD, OP_NAND: begin
            if (ins_arg != '0) begin ill_d = 1'b1; state_d = S_HALT; end
            else if (!stk_has2) begin unf_d = 1'b1; state_d = S_HALT; end
            else begin stk_op = SOP_REDUCE; pc_d = pc_q + 1'b1; end
          end
          OP_LOAD: begin
            if (stk_full) begin ovf_d = 1'b1; state_d = S_HALT; end
            else state_d = S_LOAD;
          end
          OP_STORE: begin
            if (!stk_has1) begin unf_d = 1'b1; state_d = S_HALT; end
            else begin
              mem_we    = 1'b1;
              mem_waddr = ins_arg;
              mem_wdata = stk_top;
              stk_op    = SOP_POP1;
              pc_d      = pc_q + 1'b1;
            end
          end
          OP_IMM: begin
            if (stk_full) begin ovf_d = 1'b1; state_d = S_HALT; end
            else begin stk_op = SOP_PUSH; stk_wdata = imm_ext; pc_d = pc_q + 1'b1; end
          end
          OP_BEQ: begin
            if (!stk_has2) begin unf_d = 1'b1; state_d = S_HALT; end
            else if (stk_top == stk_sec) begin stk_op = SOP_POP2; pc_d = ins_arg; end
            else pc_d = pc_q + 1'b1;
          end
          OP_STOP: begin
            if (ins_arg != '0) ill_d = 1'b1;
            else pc_d = pc_q + 1'b1;
            state_d = S_HALT;
          end
          default: begin ill_d = 1'b1; state_d = S_HALT; end
        endcase
      end
      S_LOAD: begin
        stk_op    = SOP_PUSH;
        stk_wdata = mem_rdata;
        pc_d      = pc_q + 1'b1;
        state_d   = S_FETCH;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
      ill_q   <= ill_d;
    end
  end

  assign halted        = (state_q == S_HALT);
  assign err_overflow  = ovf_q;
  assign err_underflow = unf_q;
  assign err_illegal   = ill_q;
  assign pc            = pc_q;
  assign dbg_mem_rdata = mem_rdata;

  // R7: once stopped, the core stays stopped until reset
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R8: overflow flag is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    err_overflow |=> err_overflow);
  // R10: any fault flag goes with a stopped core
  a_r10_fault_halts: assert property (@(posedge clk) disable iff (rst)
    (err_overflow || err_underflow || err_illegal) |-> halted);
  // R9: at most one fault is ever recorded
  a_r9_single_fault: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_overflow, err_underflow, err_illegal}));
  // R13: the program counter does not move while idle
  a_r13_idle_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |=> (pc_q == $past(pc_q)));
  // R7: the program counter does not move while halted
  a_r7_halt_pc_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc_q));
endmodule

// File: tb/stk8_core_bench.sv
`timescale 1ns/1ps
module stk8_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       dbg_mem_we = 1'b0;
  logic [4:0] dbg_addr = '0;
  logic [7:0] dbg_wdata = '0;
  logic       dbg_stk_push = 1'b0;
  logic [3:0] dbg_stk_idx = '0;
  logic       halted, err_overflow, err_underflow, err_illegal;
  logic [4:0] pc;
  logic [7:0] dbg_mem_rdata, dbg_stk_data;
  logic [4:0] dbg_stk_depth;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  stk8_core u_stk8_core (
    .clk(clk), .rst(rst), .run(run), .dbg_mem_we(dbg_mem_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_stk_push(dbg_stk_push),
    .dbg_stk_idx(dbg_stk_idx), .halted(halted), .err_overflow(err_overflow),
    .err_underflow(err_underflow), .err_illegal(err_illegal), .pc(pc),
    .dbg_mem_rdata(dbg_mem_rdata), .dbg_stk_depth(dbg_stk_depth),
    .dbg_stk_data(dbg_stk_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic mem_wr(input logic [4:0] a, input logic [7:0] d);
    dbg_mem_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_mem_we = 1'b0;
  endtask

  task automatic fill_mem(input logic [7:0] d);
    for (int i = 0; i < 32; i++) mem_wr(5'(i), d);
  endtask

  task automatic stk_push(input logic [7:0] d);
    dbg_stk_push = 1'b1; dbg_wdata = d;
    @(negedge clk);
    dbg_stk_push = 1'b0;
  endtask

  task automatic mem_rd(input logic [4:0] a, output logic [7:0] d);
    dbg_addr = a;
    @(negedge clk);
    d = dbg_mem_rdata;
  endtask

  task automatic stk_rd(input logic [3:0] i, output logic [7:0] d);
    dbg_stk_idx = i;
    #1;
    d = dbg_stk_data;
  endtask

  task automatic run_prog(input string tag);
    bit done = 1'b0;
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 500 && !done; i++) begin
      if (halted) done = 1'b1;
      else @(negedge clk);
    end
    chk(tag, "core reached halt", {31'd0, done}, 32'd1);
  endtask

  task automatic check_flags(input string tag, input logic o, input logic u, input logic l);
    chk(tag, "overflow flag", {31'd0, err_overflow}, {31'd0, o});
    chk(tag, "underflow flag", {31'd0, err_underflow}, {31'd0, u});
    chk(tag, "illegal flag", {31'd0, err_illegal}, {31'd0, l});
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    chk("R1", "halted", {31'd0, halted}, 32'd0);
    chk("R1", "pc", {27'd0, pc}, 32'd0);
    chk("R1", "depth", {27'd0, dbg_stk_depth}, 32'd0);
    check_flags("R1", 1'b0, 1'b0, 1'b0);
  endtask

  // R3 R4 R2: immediate pushes, add, pop to memory; then halted-state checks (R7 R13)
  task automatic t_add_pop();
    logic [7:0] d;
    do_reset();
    fill_mem(8'hC0);
    mem_wr(0, 8'h86);   // push imm 6
    mem_wr(1, 8'h88);   // push imm 8
    mem_wr(2, 8'h00);   // add
    mem_wr(3, 8'h67);   // pop to 7
    mem_wr(4, 8'hC0);   // halt
    run_prog("R3");
    mem_rd(7, d);
    chk("R3", "sum stored at 7", {24'd0, d}, 32'd14);
    chk("R4", "depth after pop", {27'd0, dbg_stk_depth}, 32'd0);
    chk("R7", "pc after halt at 4", {27'd0, pc}, 32'd5);
    check_flags("R7", 1'b0, 1'b0, 1'b0);
    // R7: run while halted has no effect
    run = 1'b1; @(negedge clk); run = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7", "pc unchanged by run when halted", {27'd0, pc}, 32'd5);
    chk("R7", "still halted", {31'd0, halted}, 32'd1);
    // R13: debug writes ignored while halted
    mem_wr(7, 8'h77);
    stk_push(8'h55);
    mem_rd(7, d);
    chk("R13", "memory write ignored when halted", {24'd0, d}, 32'd14);
    chk("R13", "stack push ignored when halted", {27'd0, dbg_stk_depth}, 32'd0);
  endtask

  // R3: nand and wrapping add with preloaded stack; R5 sign extension
  task automatic t_nand_wrap();
    logic [7:0] d;
    do_reset();
    fill_mem(8'hC0);
    stk_push(8'h80);
    stk_push(8'h90);
    mem_wr(0, 8'h00);   // add -> 0x10
    mem_wr(1, 8'h9F);   // push imm -1 -> 0xFF
    mem_wr(2, 8'h85);   // push imm 5
    mem_wr(3, 8'h20);   // nand -> 0xFA
    mem_wr(4, 8'hC0);
    run_prog("R3");
    chk("R3", "depth", {27'd0, dbg_stk_depth}, 32'd2);
    stk_rd(0, d);
    chk("R3", "wrapped sum 0x80+0x90", {24'd0, d}, 32'h10);
    stk_rd(1, d);
    chk("R3", "nand of 0xFF and 0x05", {24'd0, d}, 32'hFA);
    // R5: negative immediate pushes sign-extended
    do_reset();
    fill_mem(8'hC0);
    mem_wr(0, 8'h90);   // push imm -16
    mem_wr(1, 8'h8F);   // push imm 15
    run_prog("R5");
    stk_rd(0, d);
    chk("R5", "imm -16 extended", {24'd0, d}, 32'hF0);
    stk_rd(1, d);
    chk("R5", "imm 15 extended", {24'd0, d}, 32'h0F);
  endtask

  // R4 R2: push from address 10 via encoding 0x4A
  task automatic t_load();
    logic [7:0] d;
    do_reset();
    fill_mem(8'hC0);
    mem_wr(10, 8'h5A);
    mem_wr(0, 8'h4A);
    run_prog("R4");
    chk("R4", "depth after load", {27'd0, dbg_stk_depth}, 32'd1);
    stk_rd(0, d);
    chk("R2", "0x4A loads address 10", {24'd0, d}, 32'h5A);
    chk("R4", "pc after load and halt", {27'd0, pc}, 32'd2);
  endtask

  // R6: branch taken and not taken
  task automatic t_branch();
    logic [7:0] d;
    do_reset();
    fill_mem(8'hC0);
    mem_wr(0, 8'h83);   // push 3
    mem_wr(1, 8'h83);   // push 3
    mem_wr(2, 8'hA5);   // beq 5
    mem_wr(5, 8'h81);   // push 1
    run_prog("R6");
    chk("R6", "taken: pc", {27'd0, pc}, 32'd7);
    chk("R6", "taken: depth", {27'd0, dbg_stk_depth}, 32'd1);
    stk_rd(0, d);
    chk("R6", "taken: top", {24'd0, d}, 32'd1);
    do_reset();
    fill_mem(8'hC0);
    mem_wr(0, 8'h82);
    mem_wr(1, 8'h83);
    mem_wr(2, 8'hA5);
    run_prog("R6");
    chk("R6", "not taken: pc", {27'd0, pc}, 32'd4);
    chk("R6", "not taken: depth", {27'd0, dbg_stk_depth}, 32'd2);
    stk_rd(1, d);
    chk("R6", "not taken: top kept", {24'd0, d}, 32'd3);
  endtask

  // R11: pop overwrites a later halt with an add
  task automatic t_selfmod();
    logic [7:0] d;
    do_reset();
    fill_mem(8'hC0);
    stk_push(8'h10);
    stk_push(8'h20);
    mem_wr(0, 8'h80);   // push imm 0
    mem_wr(1, 8'h63);   // pop to 3 (turns halt into add)
    mem_wr(2, 8'h81);   // push imm 1
    mem_wr(3, 8'hC0);   // halt, overwritten
    run_prog("R11");
    chk("R11", "pc after modified code", {27'd0, pc}, 32'd5);
    chk("R11", "depth", {27'd0, dbg_stk_depth}, 32'd2);
    stk_rd(1, d);
    chk("R11", "top after injected add", {24'd0, d}, 32'h21);
    mem_rd(3, d);
    chk("R11", "code byte rewritten", {24'd0, d}, 32'h00);
  endtask

  // R12: pc wraps from 31 to 0
  task automatic t_wrap();
    logic [7:0] d;
    do_reset();
    fill_mem(8'hC0);
    stk_push(8'h07);
    stk_push(8'h07);
    mem_wr(0, 8'hBE);   // beq 30
    mem_wr(30, 8'h85);  // push 5
    mem_wr(31, 8'h86);  // push 6, then pc wraps to 0
    run_prog("R12");
    chk("R12", "pc after wrap", {27'd0, pc}, 32'd2);
    chk("R12", "depth", {27'd0, dbg_stk_depth}, 32'd2);
    stk_rd(1, d);
    chk("R12", "top", {24'd0, d}, 32'd6);
  endtask

  // R8: overflow, plus debug push ignored when full (R13)
  task automatic t_overflow();
    logic [7:0] d;
    do_reset();
    fill_mem(8'hC0);
    for (int i = 0; i < 16; i++) stk_push(8'h30 + 8'(i));
    stk_push(8'h99);
    chk("R13", "debug push ignored when full", {27'd0, dbg_stk_depth}, 32'd16);
    mem_wr(0, 8'h81);
    run_prog("R8");
    check_flags("R8", 1'b1, 1'b0, 1'b0);
    chk("R8", "pc at fault", {27'd0, pc}, 32'd0);
    chk("R8", "depth kept", {27'd0, dbg_stk_depth}, 32'd16);
    stk_rd(15, d);
    chk("R8", "top kept", {24'd0, d}, 32'h3F);
  endtask

  // R9: underflow on add with empty stack and on beq with one entry
  task automatic t_underflow();
    do_reset();
    fill_mem(8'hC0);
    mem_wr(0, 8'h00);
    run_prog("R9");
    check_flags("R9", 1'b0, 1'b1, 1'b0);
    chk("R9", "pc at fault", {27'd0, pc}, 32'd0);
    do_reset();
    fill_mem(8'hC0);
    stk_push(8'h05);
    mem_wr(0, 8'hA3);
    run_prog("R9");
    check_flags("R9", 1'b0, 1'b1, 1'b0);
    chk("R9", "depth kept", {27'd0, dbg_stk_depth}, 32'd1);
  endtask

  // R10: undefined opcode and R-type with nonzero operand
  task automatic t_illegal();
    do_reset();
    fill_mem(8'hC0);
    mem_wr(0, 8'hE0);
    run_prog("R10");
    check_flags("R10", 1'b0, 1'b0, 1'b1);
    chk("R10", "pc at fault", {27'd0, pc}, 32'd0);
    do_reset();
    fill_mem(8'hC0);
    stk_push(8'h01);
    stk_push(8'h02);
    mem_wr(0, 8'h01);
    run_prog("R10");
    check_flags("R10", 1'b0, 1'b0, 1'b1);
    chk("R10", "stack untouched", {27'd0, dbg_stk_depth}, 32'd2);
  endtask

  initial begin
    t_reset();
    t_add_pop();
    t_nand_wrap();
    t_load();
    t_branch();
    t_selfmod();
    t_wrap();
    t_overflow();
    t_underflow();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule